// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the byte that a flash memory returns on a read while an internal program or erase is running or while an erase is suspended. It sits between the array sense path and the output bus. The controller tells it the kind of operation in flight and which state that operation is in: busy, sector-acceptance window open, suspended or failed. It also gives the set of sectors marked for erase, the sector index of the current read address and the top bit of the byte being programmed. From these the block either builds a status word or lets the array byte through unchanged.

Software polls the status word to learn about progress. Bit 7 is a data-polling bit that differs from the final data until the operation completes. Bit 6 flips on every read during an active operation. Bit 2 flips only on reads that hit a sector marked for erase, so it can tell which sectors are involved. Bit 5 flags a timeout. Bit 3 shows whether more sectors may still be added. Both toggle bits advance on a one-cycle read strobe, so the number of clock cycles between reads has no effect.

Top module: `flash_op_status`

## Requirements
- R1: When neither busy nor suspended is asserted, rd_data equals array_data. Read strobes in this state leave both toggle bits unchanged. After reset both toggle bits are 0.
- R2: While a program is busy (busy=1, op_erase=0), rd_data[7] is the inverse of prog_d7 and rd_data[5] equals fail. rd_data[4:0] are all 0.
- R3: While a program is busy, or an erase is active (busy=1, op_erase=1, suspended=0), each read strobe inverts rd_data[6] for the next read.
- R4: While an erase is active, rd_data[7] is 0 and rd_data[5] equals fail. rd_data[3] is 0 while window_open=1 and 1 while window_open=0. rd_data[4], rd_data[1] and rd_data[0] are 0.
- R5: rd_data[2] in an active erase, or in a suspended read of an erase-set sector, inverts after a read strobe only when erase_set[rd_sect] is 1. Otherwise it holds its value.
- R6: While suspended=1 and erase_set[rd_sect]=1, with no program busy, rd_data[7] is 1 and rd_data[5:3] and rd_data[1:0] are 0. Bit 6 shows the held toggle value and does not change on a read strobe.
- R7: While suspended=1 and erase_set[rd_sect]=0, with no program busy, rd_data equals array_data.
- R8: A busy program (busy=1, op_erase=0) issued while suspended=1 returns the R2 status pattern for every sector, including sectors in the erase set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the toggle bits |
| op_erase | input | 1 | Operation kind: 1 = erase, 0 = program |
| busy | input | 1 | Embedded operation in progress |
| window_open | input | 1 | Sector-acceptance window of an erase is still open |
| suspended | input | 1 | Erase is suspended |
| fail | input | 1 | Operation exceeded its time limit |
| erase_set | input | 2**SECT_W | One bit per sector, 1 = sector is marked for erase |
| rd_sect | input | SECT_W | Sector index taken from the read address |
| prog_d7 | input | 1 | Bit 7 of the byte being programmed |
| array_data | input | 8 | Byte read from the array |
| rd_strobe | input | 1 | One-cycle pulse per read; advances the toggle bits |
| rd_data | output | 8 | Status word or array byte |

## Verification
The suspended state is swept over every erase-set mask and every sector index. This tells the status word apart from pass-through data, and shows that bit 2 advances while bit 6 stands still. The program state is tried with both values of the programmed top bit and of the fail flag, each under sequences of reads, to separate the polling bit, the timeout bit and the read-counted toggle. The active erase state is tried with the window open and closed across all sectors, which tells the bit 3 encoding and the sector-selective bit 2 apart from the unconditional bit 6. A program during suspend and an idle phase that follows confirm that program has priority, that a finished operation passes data through, and that the toggles stop.

// File: rtl/flash_op_status.sv
module flash_op_status #(
  parameter int SECT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_erase,
  input  logic                     busy,
  input  logic                     window_open,
  input  logic                     suspended,
  input  logic                     fail,
  input  logic [(1<<SECT_W)-1:0]   erase_set,
  input  logic [SECT_W-1:0]        rd_sect,
  input  logic                     prog_d7,
  input  logic [7:0]               array_data,
  input  logic                     rd_strobe,
  output logic [7:0]               rd_data
);
  localparam int NSECT = 1 << SECT_W;

  logic in_set, prog_mode, ers_mode, susp_hit;
  logic tgl6, tgl2;

  assign in_set    = erase_set[rd_sect];
  assign prog_mode = busy & ~op_erase;
  assign ers_mode  = busy & op_erase & ~suspended;
  assign susp_hit  = suspended & in_set & ~prog_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgl6 <= 1'b0;
      tgl2 <= 1'b0;
    end else if (rd_strobe) begin
      if (prog_mode | ers_mode)
        tgl6 <= ~tgl6;
      if ((ers_mode | susp_hit) & in_set)
        tgl2 <= ~tgl2;
    end
  end

  always_comb begin
    if (prog_mode)
      rd_data = {~prog_d7, tgl6, fail, 5'b00000};
    else if (ers_mode)
      rd_data = {1'b0, tgl6, fail, 1'b0, ~window_open, tgl2, 2'b00};
    else if (susp_hit)
      rd_data = {1'b1, tgl6, 3'b000, tgl2, 2'b00};
    else
      rd_data = array_data;
  end

  // R3
  bit6_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && (prog_mode || ers_mode)) |=> (tgl6 != $past(tgl6)));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !busy && !suspended) |=> ($stable(tgl6) && $stable(tgl2)));

  // R5
  bit2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !in_set) |=> $stable(tgl2));

  // R6
  susp_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && suspended && !busy) |=> $stable(tgl6));

  // R7
  susp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !busy && !in_set) |-> (rd_data == array_data));

  // R2
  prog_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |-> (rd_data[4:0] == 5'b00000));

  initial assert (NSECT >= 2);
endmodule

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;
  localparam int SW = 3;
  localparam int NS = 1 << SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_erase = 1'b0, busy = 1'b0, window_open = 1'b0, suspended = 1'b0, fail = 1'b0;
  logic [NS-1:0] erase_set = '0;
  logic [SW-1:0] rd_sect = '0;
  logic prog_d7 = 1'b0;
  logic [7:0] array_data = 8'h00;
  logic rd_strobe = 1'b0;
  logic [7:0] rd_data;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic m6 = 1'b0, m2 = 1'b0;

  always #2.5 clk = ~clk;

  flash_op_status #(.SECT_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .op_erase(op_erase), .busy(busy),
    .window_open(window_open), .suspended(suspended), .fail(fail),
    .erase_set(erase_set), .rd_sect(rd_sect), .prog_d7(prog_d7),
    .array_data(array_data), .rd_strobe(rd_strobe), .rd_data(rd_data));

  function automatic logic [7:0] expect_byte();
    logic hit = erase_set[rd_sect];
    if (busy && !op_erase)             return {~prog_d7, m6, fail, 5'b0};
    if (busy && op_erase && !suspended) return {1'b0, m6, fail, 1'b0, ~window_open, m2, 2'b0};
    if (suspended && hit)              return {1'b1, m6, 3'b0, m2, 2'b0};
    return array_data;
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, exp);
    end
  endtask

  task automatic rd(string tag);
    logic prog, ers, hit;
    @(negedge clk);
    rd_strobe = 1'b1;
    #1;
    check(tag, expect_byte());
    prog = busy && !op_erase;
    ers  = busy && op_erase && !suspended;
    hit  = erase_set[rd_sect];
    if (prog || ers) m6 = ~m6;
    if ((ers || (suspended && hit && !prog)) && hit) m2 = ~m2;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    array_data = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 reset pass-through", 8'h5A);

    // R1 idle sweep: pass-through, toggles frozen
    for (int v = 0; v < 256; v++) begin
      array_data = 8'(v);
      rd("R1 idle");
    end

    // R2 / R3 program busy
    busy = 1'b1; op_erase = 1'b0;
    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 2; f++) begin
        prog_d7 = d[0]; fail = f[0]; array_data = 8'(d * 16 + f);
        for (int k = 0; k < 4; k++) rd("R2 R3 program status");
      end
    fail = 1'b0;

    // R4 / R5 / R3 erase active
    op_erase = 1'b1; erase_set = 8'hA5;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < NS; s++) begin
        window_open = w[0]; rd_sect = SW'(s); fail = s[0];
        rd("R4 R5 erase active");
        rd("R3 R5 erase active");
      end
    fail = 1'b0; window_open = 1'b0;

    // R6 / R7 / R5 suspend sweep over every mask and sector
    busy = 1'b0; suspended = 1'b1;
    for (int m = 0; m < 256; m++)
      for (int s = 0; s < NS; s++) begin
        erase_set = 8'(m); rd_sect = SW'(s); array_data = 8'(m ^ (s * 37));
        if (m[s]) rd("R6 R5 suspend in set");
        else      rd("R7 suspend outside set");
      end

    // R8 program during suspend
    busy = 1'b1; op_erase = 1'b0; erase_set = 8'hFF;
    for (int s = 0; s < NS; s++) begin
      rd_sect = SW'(s); prog_d7 = s[1];
      rd("R8 suspended program");
    end

    // R1 finished: pass-through, toggles stop
    busy = 1'b0; suspended = 1'b0;
    for (int v = 0; v < 16; v++) begin
      array_data = 8'(v * 17);
      rd("R1 finished");
    end
    busy = 1'b1; op_erase = 1'b0; prog_d7 = 1'b1;
    rd("R1 R3 toggle state kept after idle");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule